// File: doc/BRIEF.md
# PWM Timer Channel with Safe Stop

This block is one pulse-width-modulated timer channel. Software writes a high-time value and a control byte through a small write port. While the channel runs in PWM mode it counts externally supplied count ticks, one period per 256 ticks, and holds its output at the active level for the programmed number of ticks at the start of each period. A polarity bit picks the idle level. The active level is its inverse.

When software clears the run bit during a pulse, the output goes to the idle level at once. The interrupt flag is raised only if that stop changed the output level. An interrupt flag also marks the end of every active pulse and certain entries into PWM mode. The flag is cleared by a one-cycle strobe. When a shutdown-enable bit is set, an active-low shutdown input takes the output enable away without a clock. The counter keeps running.

Register map (`wr_addr_i`): address 0 is control, with bit 0 = run, bit 1 = polarity, bit 2 = shutdown enable, and bits 4:3 = mode (00 timer, 01 event counter, 10 PWM, 11 one-shot). Address 1 is the high-time buffer. Other addresses are ignored.

Top module: `pwm_safe_stop_timer`

## Requirements
- R1: After reset the channel is stopped, the mode is timer (00), the polarity is 0, the shutdown enable is 0, `pwm_o` is 0, `pwm_oe_o` is 1 and `irq_o` is 0. Ticks do not move the output while the channel is stopped.
- R2: The polarity, shutdown-enable and mode fields of the control byte (address 0) are taken only when the run bit is currently 0. While the channel runs, a control write changes only the run bit.
- R3: An accepted control write that switches the mode to PWM (10) sets `irq_o` in these cases: the previous mode was timer (00) or event counter (01), or PWM has never been selected since reset. A switch from one-shot (11) after an earlier PWM selection does not set it.
- R4: While running in PWM mode, the count advances by one per cycle with `tick_i` high and wraps after 256 ticks. The output is active while the count is below the current high time. `pwm_o` equals the active flag XOR the polarity bit.
- R5: The high-time register (address 1) is a buffer. The buffered value takes effect at the next period start, which is either a count wrap to 0 or a start.
- R6: `irq_o` is set on the tick that ends an active pulse. A high time of 0 gives no pulse and no interrupt for the whole period.
- R7: Writing run=1 with mode PWM while stopped restarts at count 0 with the output at the active level, unless the buffered high time is 0.
- R8: With polarity 0, clearing run during a high output drives `pwm_o` low and sets `irq_o`. If the output is already low, neither changes.
- R9: With polarity 1, clearing run during a low output drives `pwm_o` high and sets `irq_o`. If the output is already high, neither changes.
- R10: When the shutdown enable is 1 and `shutdown_ni` is 0, `pwm_oe_o` is 0 in the same cycle without a clock edge. The counter and the output level keep advancing as normal.
- R11: A one-cycle `irq_clr_i` clears `irq_o` on the next edge. If a set event falls in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Register write data |
| tick_i | input | 1 | Count enable, one tick per high cycle |
| shutdown_ni | input | 1 | Active-low shutdown request |
| irq_clr_i | input | 1 | One-cycle clear of the interrupt flag |
| pwm_o | output | 1 | PWM output level |
| pwm_oe_o | output | 1 | Output enable for `pwm_o` (0 = high impedance) |
| irq_o | output | 1 | Interrupt request flag |

## Verification
Every registered result appears after the clock edge that samples its cause. This applies to writes, to start, to stop and to clears: `pwm_o` and `irq_o` reflect the edge that took a write or a tick. The bench drives inputs on the falling edge and samples on the next falling edge, half a period after the deciding rising edge. The shutdown effect on `pwm_oe_o` has no register in its path, so it is checked one time unit after `shutdown_ni` changes, before any rising edge. Tick counts are tracked by the bench, so each check falls on the exact count where a period wraps or a pulse ends.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER   = 2'b00,
    MODE_EVENT   = 2'b01,
    MODE_PWM     = 2'b10,
    MODE_ONESHOT = 2'b11
  } mode_e;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_HIGH = 1;

  localparam int RUN_BIT  = 0;
  localparam int POL_BIT  = 1;
  localparam int SDEN_BIT = 2;
  localparam int MODE_LO  = 3;
  localparam int MODE_HI  = 4;
endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pol_o,
  output logic              sd_en_o,
  output logic [DATA_W-1:0] hi_buf_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              mode_entry_o
);
  logic              run_q, pol_q, sd_en_q, seen_pwm_q;
  mode_e             mode_q, wr_mode;
  logic [DATA_W-1:0] hi_buf_q;
  logic              ctrl_wr, hi_wr, cfg_ok;
  logic              unused_ctrl_bits;

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL));
  assign hi_wr   = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_HIGH));
  assign cfg_ok  = ctrl_wr && !run_q;
  assign wr_mode = mode_e'(wr_data_i[MODE_HI:MODE_LO]);
  assign unused_ctrl_bits = ^wr_data_i[DATA_W-1:MODE_HI+1];

  assign start_o = ctrl_wr && wr_data_i[RUN_BIT] && !run_q && (wr_mode == MODE_PWM);
  assign stop_o  = ctrl_wr && !wr_data_i[RUN_BIT] && run_q && (mode_q == MODE_PWM);
  // entry from timer/event, or first ever entry
  assign mode_entry_o = cfg_ok && (wr_mode == MODE_PWM) && (mode_q != MODE_PWM) &&
                        ((mode_q == MODE_TIMER) || (mode_q == MODE_EVENT) || !seen_pwm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      pol_q      <= 1'b0;
      sd_en_q    <= 1'b0;
      mode_q     <= MODE_TIMER;
      seen_pwm_q <= 1'b0;
      hi_buf_q   <= '0;
    end else begin
      if (ctrl_wr) run_q <= wr_data_i[RUN_BIT];
      if (cfg_ok) begin
        pol_q   <= wr_data_i[POL_BIT];
        sd_en_q <= wr_data_i[SDEN_BIT];
        mode_q  <= wr_mode;
        if (wr_mode == MODE_PWM) seen_pwm_q <= 1'b1;
      end
      if (hi_wr) hi_buf_q <= wr_data_i;
    end
  end

  assign pol_o    = pol_q;
  assign sd_en_o  = sd_en_q;
  assign hi_buf_o = hi_buf_q;

  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && run_q) |=> ($stable(pol_q) && $stable(sd_en_q) && $stable(mode_q)));

  p_entry_mode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_entry_o |=> (mode_q == MODE_PWM) && seen_pwm_q);
endmodule

// File: rtl/pwm_tmr_core.sv
module pwm_tmr_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] hi_buf_i,
  output logic             active_o,
  output logic             set_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             run_q, act_q;
  logic [CNT_W-1:0] cnt_q, hi_cur_q, cnt_nxt;
  logic             wrap, act_nxt, step;

  assign cnt_nxt = cnt_q + 1'b1;
  assign wrap    = (cnt_nxt == '0);
  assign act_nxt = wrap ? (hi_buf_i != '0) : (cnt_nxt < hi_cur_q);
  assign step    = run_q && tick_i && !start_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      act_q    <= 1'b0;
      cnt_q    <= '0;
      hi_cur_q <= '0;
    end else if (start_i) begin
      run_q    <= 1'b1;
      cnt_q    <= '0;
      hi_cur_q <= hi_buf_i;
      act_q    <= (hi_buf_i != '0);
    end else if (stop_i) begin
      run_q <= 1'b0;
      act_q <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_nxt;
      act_q <= act_nxt;
      if (wrap) hi_cur_q <= hi_buf_i;
    end
  end

  // pulse end, or stop that leaves the active level
  assign set_o    = (step && act_q && !act_nxt) || (stop_i && act_q);
  assign active_o = act_q;
  assign cnt_o    = cnt_q;

  p_stop_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !act_q && !run_q);

  p_start_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == '0) && (act_q == ($past(hi_buf_i) != '0)));

  p_no_tick_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !start_i && !stop_i) |=> $stable(cnt_q) && $stable(act_q));

  p_hi_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && wrap) |=> (hi_cur_q == $past(hi_buf_i)));
endmodule

// File: rtl/pwm_tmr_irq.sv
module pwm_tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> irq_q);

  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !irq_q);
endmodule

// File: rtl/pwm_safe_stop_timer.sv
module pwm_safe_stop_timer
  import pwm_tmr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              tick_i,
  input  logic              shutdown_ni,
  input  logic              irq_clr_i,
  output logic              pwm_o,
  output logic              pwm_oe_o,
  output logic              irq_o
);
  logic             pol, sd_en, start, stop, mode_entry;
  logic             active, core_set;
  logic [CNT_W-1:0] hi_buf, cnt;

  pwm_tmr_regs #(.ADDR_W(ADDR_W), .DATA_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .pol_o(pol), .sd_en_o(sd_en), .hi_buf_o(hi_buf),
    .start_o(start), .stop_o(stop), .mode_entry_o(mode_entry)
  );

  pwm_tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .tick_i,
    .start_i(start), .stop_i(stop), .hi_buf_i(hi_buf),
    .active_o(active), .set_o(core_set), .cnt_o(cnt)
  );

  pwm_tmr_irq u_irq (
    .clk_i, .rst_ni,
    .set_i(core_set || mode_entry), .clr_i(irq_clr_i), .irq_o
  );

  assign pwm_o    = active ^ pol;
  assign pwm_oe_o = !(sd_en && !shutdown_ni);

  // shutdown never disturbs the count
  p_shutdown_count_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shutdown_ni && !tick_i && !start && !stop) |=> $stable(cnt) && $stable(active));

  p_stop_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (pwm_o == pol));
endmodule

// File: tb/pwm_safe_stop_timer_test.sv
module pwm_safe_stop_timer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       tick_i = 1'b0;
  logic       shutdown_ni = 1'b1;
  logic       irq_clr_i = 1'b0;
  logic       pwm_o, pwm_oe_o, irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pwm_safe_stop_timer uut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] ctrl(bit run, bit pol, bit sd, logic [1:0] mode);
    return {3'b000, mode, sd, pol, run};
  endfunction

  // all tasks start and end on a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic clr();
    irq_clr_i = 1'b1;
    @(negedge clk_i);
    irq_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pwm", pwm_o, 0);
    chk("R1 oe", pwm_oe_o, 1);
    chk("R1 irq", irq_o, 0);
    ticks(5);
    chk("R1 stopped pwm", pwm_o, 0);
    chk("R1 stopped irq", irq_o, 0);
  endtask

  task automatic t_mode_entry();
    wr(0, ctrl(0, 0, 0, 2'b11));
    chk("R3 oneshot no irq", irq_o, 0);
    wr(0, ctrl(0, 0, 0, 2'b10));
    chk("R3 first pwm irq", irq_o, 1);
    clr();
    chk("R11 clear", irq_o, 0);
    wr(0, ctrl(0, 0, 0, 2'b11));
    wr(0, ctrl(0, 0, 0, 2'b10));
    chk("R3 from oneshot no irq", irq_o, 0);
    wr(0, ctrl(0, 0, 0, 2'b01));
    wr(0, ctrl(0, 0, 0, 2'b10));
    chk("R3 from event irq", irq_o, 1);
    clr();
    wr(0, ctrl(0, 0, 0, 2'b00));
    wr(0, ctrl(0, 0, 0, 2'b10));
    chk("R3 from timer irq", irq_o, 1);
    clr();
    wr(0, ctrl(0, 0, 0, 2'b10));
    chk("R3 pwm to pwm no irq", irq_o, 0);
  endtask

  task automatic t_basic();
    wr(1, 8'd3);
    wr(0, ctrl(1, 0, 0, 2'b10));
    chk("R7 start active", pwm_o, 1);
    ticks(2);
    chk("R4 cnt2 active", pwm_o, 1);
    chk("R6 no early irq", irq_o, 0);
    ticks(1);
    chk("R4 cnt3 inactive", pwm_o, 0);
    chk("R6 pulse end irq", irq_o, 1);
    clr();
    ticks(100);
    wr(1, 8'd5);
    chk("R5 buffered no effect", pwm_o, 0);
    ticks(152);
    chk("R4 cnt255 inactive", pwm_o, 0);
    chk("R5 no irq mid period", irq_o, 0);
    ticks(1);
    chk("R4 wrap active", pwm_o, 1);
    ticks(4);
    chk("R5 new high time held", pwm_o, 1);
    ticks(1);
    chk("R5 new high time end", pwm_o, 0);
    chk("R6 irq new period", irq_o, 1);
    clr();
    wr(0, ctrl(0, 0, 0, 2'b10));
    chk("R8 stop low level", pwm_o, 0);
    chk("R8 stop low no irq", irq_o, 0);
  endtask

  task automatic t_stop_pol0();
    wr(1, 8'd20);
    wr(0, ctrl(1, 0, 0, 2'b10));
    ticks(10);
    chk("R4 mid pulse", pwm_o, 1);
    wr(0, ctrl(0, 0, 0, 2'b10));
    chk("R8 stop high goes low", pwm_o, 0);
    chk("R8 stop high irq", irq_o, 1);
    clr();
    ticks(3);
    chk("R8 stays stopped", pwm_o, 0);
    wr(0, ctrl(1, 0, 0, 2'b10));
    chk("R7 restart active", pwm_o, 1);
    ticks(19);
    chk("R7 restart count 19", pwm_o, 1);
    ticks(1);
    chk("R7 restart from zero", pwm_o, 0);
    chk("R6 restart pulse irq", irq_o, 1);
    clr();
    wr(0, ctrl(0, 0, 0, 2'b10));
  endtask

  task automatic t_pol1();
    wr(0, ctrl(0, 1, 0, 2'b10));
    chk("R9 idle high", pwm_o, 1);
    wr(1, 8'd2);
    wr(0, ctrl(1, 1, 0, 2'b10));
    chk("R9 active low", pwm_o, 0);
    ticks(1);
    wr(0, ctrl(0, 1, 0, 2'b10));
    chk("R9 stop low goes high", pwm_o, 1);
    chk("R9 stop low irq", irq_o, 1);
    clr();
    wr(0, ctrl(1, 1, 0, 2'b10));
    ticks(2);
    chk("R9 inactive high", pwm_o, 1);
    chk("R6 pol1 pulse irq", irq_o, 1);
    clr();
    wr(0, ctrl(0, 1, 0, 2'b10));
    chk("R9 stop high stays", pwm_o, 1);
    chk("R9 stop high no irq", irq_o, 0);
    wr(0, ctrl(0, 0, 0, 2'b10));
    chk("R2 pol write when stopped", pwm_o, 0);
  endtask

  task automatic t_cfg_ignored();
    wr(1, 8'd100);
    wr(0, ctrl(1, 0, 0, 2'b10));
    wr(0, ctrl(1, 1, 1, 2'b01));
    chk("R2 pol ignored running", pwm_o, 1);
    chk("R2 no irq", irq_o, 0);
    shutdown_ni = 1'b0;
    #1;
    chk("R2 sd enable ignored", pwm_oe_o, 1);
    shutdown_ni = 1'b1;
    @(negedge clk_i);
    ticks(1);
    chk("R2 mode ignored still pwm", pwm_o, 1);
    wr(0, ctrl(0, 0, 0, 2'b10));
    chk("R2 stop still pwm", pwm_o, 0);
    chk("R2 stop irq", irq_o, 1);
    clr();
    wr(0, ctrl(0, 0, 0, 2'b10));
    chk("R2 mode kept pwm no entry irq", irq_o, 0);
  endtask

  task automatic t_shutdown();
    wr(0, ctrl(0, 0, 1, 2'b10));
    wr(1, 8'd5);
    wr(0, ctrl(1, 0, 1, 2'b10));
    chk("R10 oe before", pwm_oe_o, 1);
    chk("R10 pwm active", pwm_o, 1);
    shutdown_ni = 1'b0;
    #1;
    chk("R10 oe comb off", pwm_oe_o, 0);
    @(negedge clk_i);
    ticks(5);
    chk("R10 oe held off", pwm_oe_o, 0);
    chk("R10 count ran level", pwm_o, 0);
    chk("R10 count ran irq", irq_o, 1);
    shutdown_ni = 1'b1;
    #1;
    chk("R10 oe back", pwm_oe_o, 1);
    @(negedge clk_i);
    clr();
    wr(0, ctrl(0, 0, 1, 2'b10));
    wr(0, ctrl(0, 0, 0, 2'b10));
  endtask

  task automatic t_hi_zero();
    wr(1, 8'd0);
    wr(0, ctrl(1, 0, 0, 2'b10));
    chk("R7 zero high inactive", pwm_o, 0);
    ticks(128);
    chk("R6 zero high mid", pwm_o, 0);
    ticks(172);
    chk("R6 zero high no pulse", pwm_o, 0);
    chk("R6 zero high no irq", irq_o, 0);
    wr(0, ctrl(0, 0, 0, 2'b10));
    chk("R8 zero high stop no irq", irq_o, 0);
  endtask

  task automatic t_set_wins();
    wr(1, 8'd1);
    wr(0, ctrl(1, 0, 0, 2'b10));
    chk("R4 high one active", pwm_o, 1);
    tick_i = 1'b1;
    irq_clr_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    irq_clr_i = 1'b0;
    chk("R11 set wins", irq_o, 1);
    chk("R4 high one ends", pwm_o, 0);
    clr();
    chk("R11 clear after", irq_o, 0);
    wr(0, ctrl(0, 0, 0, 2'b10));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mode_entry();
    t_basic();
    t_stop_pol0();
    t_pol1();
    t_cfg_ignored();
    t_shutdown();
    t_hi_zero();
    t_set_wins();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule